// File: doc/BRIEF.md
# Capture Front-End Bring-Up Sequencer

This block runs the bring-up of a two-converter sampling front end from the control clock. A run begins on any of three triggers: a force request, a rising edge on the I/O enable, or any change in the sample-clock select value. Each run walks five stages in a fixed order: PLL reset, deserializer reset, capture-delay recalibration, converter-to-converter alignment and error clear. Every stage is a request/acknowledge handshake with logic outside this block. When the last stage is acknowledged, the ready flag rises.

Only the I/O-enable trigger also asks for a reset of the converters' own registers. That request is a single-cycle pulse. The other two triggers leave those registers alone. Each converter has a sticky fault flag that records a capture window reported too narrow. A sticky unlock flag records loss of PLL lock while the block is ready, and it gates the downstream module clock enable. Each stage has a cycle budget; if it runs out, the block reports a stage failure.

Top module: `fe_init_seq`

## Requirements
- R1: When a trigger is sampled on a clock edge, the sequence restarts at that edge. From the following cycle, `init_done_o` is low and stage 0 is requested. This is well inside a 4-cycle bound.
- R2: Stages are requested one at a time, in the order bit 0 (PLL reset), bit 1 (deserializer reset), bit 2 (delay recalibration), bit 3 (converter alignment), bit 4 (error clear). A request stays high until its own acknowledge is sampled.
- R3: `init_done_o` rises in the cycle after the bit 4 acknowledge is accepted. It is never high earlier in a run.
- R4: A rising edge on `io_enable_i` produces a one-cycle `conv_reg_reset_o` pulse in the cycle after that edge. Force and clock-select triggers produce no pulse.
- R5: A high bit of `window_narrow_i` sets the matching bit of `conv_err_o` on the next cycle. That bit holds through later triggers and clears only when the bit 4 stage is acknowledged.
- R6: Loss of PLL lock while `init_done_o` is high sets `pll_unlocked_o`. The flag holds until the next trigger clears it. Loss of lock during a run is ignored.
- R7: `mod_clk_en_o` is high only while `init_done_o` is high and `pll_unlocked_o` is low.
- R8: If a stage goes STAGE_TIMEOUT cycles without an acknowledge, `stage_fail_o` rises on that cycle count after the request appeared. All requests then drop, and `init_done_o` stays low until a later run completes.
- R9: A trigger during a run drops the current request and restarts from stage 0.
- R10: While reset is asserted, and after it with no trigger, every output is low.
- R11: Holding `io_enable_i` high or keeping `clk_sel_i` steady does not start a new run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| force_init_i | input | 1 | Force a new bring-up run |
| io_enable_i | input | 1 | I/O enable; a rising edge starts a run |
| clk_sel_i | input | SEL_W | Sample-clock select; any change starts a run |
| stage_req_o | output | 5 | One-hot stage request |
| stage_ack_i | input | 5 | Per-stage acknowledge |
| window_narrow_i | input | NCONV | Per-converter narrow capture window report |
| pll_locked_i | input | 1 | PLL lock indication |
| init_done_o | output | 1 | Bring-up complete |
| stage_fail_o | output | 1 | A stage timed out |
| conv_err_o | output | NCONV | Sticky per-converter window fault |
| pll_unlocked_o | output | 1 | Sticky loss of lock since bring-up |
| mod_clk_en_o | output | 1 | Gated module clock enable |
| conv_reg_reset_o | output | 1 | One-cycle converter register reset request |

## Verification
The assertions check the following on every cycle:
- at most one stage is requested;
- a force drops the ready flag on the next cycle;
- an I/O-enable edge produces the register reset pulse, and the pulse never appears otherwise;
- ready rises only after the error-clear handshake;
- fault flags clear only at that handshake;
- the unlock flag blocks the clock enable;
- a failed run stays quiet.

Other behaviour only the bench scenarios can show: the exact stage order, the timeout landing on the budgeted cycle, restart from stage 0 in mid-run, sticky flags surviving a new run until its clear stage, and unlock being ignored during a run.

// File: rtl/fe_init_pkg.sv
package fe_init_pkg;
    localparam int unsigned NSTG       = 5;
    localparam int unsigned STG_W      = $clog2(NSTG);
    localparam int unsigned STG_CLRERR = NSTG - 1;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_RUN,
        SQ_DONE,
        SQ_FAIL
    } seq_state_e;

    typedef struct packed {
        seq_state_e        state;
        logic [STG_W-1:0]  stg;
        logic              conv_rst;
    } seq_regs_t;
endpackage

// File: rtl/fe_trig_detect.sv
module fe_trig_detect #(
    parameter int unsigned SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             force_i,
    input  logic             io_en_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic             trig_o,
    output logic             io_rise_o
);
    typedef struct packed {
        logic             io;
        logic [SEL_W-1:0] sel;
    } hist_t;

    hist_t hist_d, hist_q;
    logic  sel_chg;

    always_comb begin
        hist_d.io  = io_en_i;
        hist_d.sel = sel_i;
        io_rise_o  = io_en_i & ~hist_q.io;
        sel_chg    = (sel_i != hist_q.sel);
        trig_o     = force_i | io_rise_o | sel_chg;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hist_q <= '0;
        end else begin
            hist_q <= hist_d;
        end
    end
endmodule

// File: rtl/fe_stage_timer.sv
module fe_stage_timer #(
    parameter int unsigned LIMIT = 80_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic expired_o
);
    localparam int unsigned CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LAST_CNT = CW'(LIMIT - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d     = run_i ? cnt_q + 1'b1 : '0;
        expired_o = run_i && (cnt_q == LAST_CNT);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end
endmodule

// File: rtl/fe_sticky_flags.sv
module fe_sticky_flags #(
    parameter int unsigned N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic         clr_i,
    output logic [N-1:0] flag_o
);
    logic [N-1:0] flag_d, flag_q;

    for (genvar g = 0; g < N; g++) begin : g_flag
        always_comb begin
            flag_d[g] = clr_i ? 1'b0 : (flag_q[g] | set_i[g]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q <= '0;
        end else begin
            flag_q <= flag_d;
        end
    end

    assign flag_o = flag_q;
endmodule

// File: rtl/fe_init_seq.sv
module fe_init_seq
    import fe_init_pkg::*;
#(
    parameter int unsigned SEL_W         = 2,
    parameter int unsigned STAGE_TIMEOUT = 80_000_000,
    parameter int unsigned NCONV         = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             force_init_i,
    input  logic             io_enable_i,
    input  logic [SEL_W-1:0] clk_sel_i,
    output logic [NSTG-1:0]  stage_req_o,
    input  logic [NSTG-1:0]  stage_ack_i,
    input  logic [NCONV-1:0] window_narrow_i,
    input  logic             pll_locked_i,
    output logic             init_done_o,
    output logic             stage_fail_o,
    output logic [NCONV-1:0] conv_err_o,
    output logic             pll_unlocked_o,
    output logic             mod_clk_en_o,
    output logic             conv_reg_reset_o
);
    localparam logic [STG_W-1:0] LAST_STG = STG_W'(STG_CLRERR);

    seq_regs_t regs_d, regs_q;
    logic      trig, io_rise, expired, ack_cur, last_ack, run_timer, pll_set;
    logic [0:0] unlock_flag;

    fe_trig_detect #(.SEL_W(SEL_W)) i_trig (
        .clk       (clk),
        .rst_n     (rst_n),
        .force_i   (force_init_i),
        .io_en_i   (io_enable_i),
        .sel_i     (clk_sel_i),
        .trig_o    (trig),
        .io_rise_o (io_rise)
    );

    always_comb begin
        ack_cur   = (regs_q.state == SQ_RUN) && stage_ack_i[regs_q.stg];
        last_ack  = ack_cur && (regs_q.stg == LAST_STG);
        run_timer = (regs_q.state == SQ_RUN) && !ack_cur && !trig;
        pll_set   = (regs_q.state == SQ_DONE) && !pll_locked_i;
    end

    fe_stage_timer #(.LIMIT(STAGE_TIMEOUT)) i_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (run_timer),
        .expired_o (expired)
    );

    always_comb begin
        regs_d          = regs_q;
        regs_d.conv_rst = io_rise;
        if (trig) begin
            regs_d.state = SQ_RUN;
            regs_d.stg   = '0;
        end else begin
            unique case (regs_q.state)
                SQ_RUN: begin
                    if (ack_cur) begin
                        if (regs_q.stg == LAST_STG) begin
                            regs_d.state = SQ_DONE;
                        end else begin
                            regs_d.stg = regs_q.stg + 1'b1;
                        end
                    end else if (expired) begin
                        regs_d.state = SQ_FAIL;
                    end
                end
                default: regs_d.state = regs_q.state;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '{state: SQ_IDLE, stg: '0, conv_rst: 1'b0};
        end else begin
            regs_q <= regs_d;
        end
    end

    always_comb begin
        stage_req_o = '0;
        if (regs_q.state == SQ_RUN) begin
            stage_req_o[regs_q.stg] = 1'b1;
        end
    end

    fe_sticky_flags #(.N(NCONV)) i_conv_err (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (window_narrow_i),
        .clr_i  (last_ack),
        .flag_o (conv_err_o)
    );

    fe_sticky_flags #(.N(1)) i_unlock (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (pll_set),
        .clr_i  (trig),
        .flag_o (unlock_flag)
    );

    assign pll_unlocked_o   = unlock_flag[0];
    assign init_done_o      = (regs_q.state == SQ_DONE);
    assign stage_fail_o     = (regs_q.state == SQ_FAIL);
    assign mod_clk_en_o     = init_done_o & ~pll_unlocked_o;
    assign conv_reg_reset_o = regs_q.conv_rst;
endmodule

// File: rtl/fe_init_seq_chk.sv
module fe_init_seq_chk
    import fe_init_pkg::*;
#(
    parameter int unsigned NCONV = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             force_init_i,
    input logic             io_enable_i,
    input logic [NSTG-1:0]  stage_req_o,
    input logic [NSTG-1:0]  stage_ack_i,
    input logic             init_done_o,
    input logic             stage_fail_o,
    input logic [NCONV-1:0] conv_err_o,
    input logic             pll_unlocked_o,
    input logic             mod_clk_en_o,
    input logic             conv_reg_reset_o
);
    AST_ONE_STAGE: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(stage_req_o)); // R2
    AST_FORCE_DROPS_DONE: assert property (@(posedge clk) disable iff (!rst_n) force_init_i |=> !init_done_o); // R1
    AST_IO_RESET_REQ: assert property (@(posedge clk) disable iff (!rst_n) $rose(io_enable_i) |=> conv_reg_reset_o); // R4
    AST_RESET_REQ_SOURCE: assert property (@(posedge clk) disable iff (!rst_n) conv_reg_reset_o |-> $past(io_enable_i)); // R4
    AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n) $rose(init_done_o) |-> $past(stage_req_o[NSTG-1] && stage_ack_i[NSTG-1])); // R3
    AST_ERR_CLEAR_AT_STAGE: assert property (@(posedge clk) disable iff (!rst_n) (|($past(conv_err_o) & ~conv_err_o)) |-> $past(stage_req_o[NSTG-1] && stage_ack_i[NSTG-1])); // R5
    AST_UNLOCK_CLEAR: assert property (@(posedge clk) disable iff (!rst_n) $fell(pll_unlocked_o) |-> !init_done_o); // R6
    AST_UNLOCK_GATES_CLK: assert property (@(posedge clk) disable iff (!rst_n) pll_unlocked_o |-> !mod_clk_en_o); // R7
    AST_FAIL_QUIET: assert property (@(posedge clk) disable iff (!rst_n) stage_fail_o |-> (!init_done_o && stage_req_o == '0)); // R8
endmodule

bind fe_init_seq fe_init_seq_chk #(.NCONV(NCONV)) i_fe_init_seq_chk (
    .clk              (clk),
    .rst_n            (rst_n),
    .force_init_i     (force_init_i),
    .io_enable_i      (io_enable_i),
    .stage_req_o      (stage_req_o),
    .stage_ack_i      (stage_ack_i),
    .init_done_o      (init_done_o),
    .stage_fail_o     (stage_fail_o),
    .conv_err_o       (conv_err_o),
    .pll_unlocked_o   (pll_unlocked_o),
    .mod_clk_en_o     (mod_clk_en_o),
    .conv_reg_reset_o (conv_reg_reset_o)
);

// File: tb/test_fe_init_seq.sv
module test_fe_init_seq;
    localparam int TMO   = 16;
    localparam int NS    = 5;
    localparam int SEL_W = 2;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             force_init = 1'b0;
    logic             io_enable = 1'b0;
    logic [SEL_W-1:0] clk_sel = '0;
    logic [NS-1:0]    stage_req;
    logic [NS-1:0]    stage_ack = '0;
    logic [1:0]       narrow = '0;
    logic             pll_locked = 1'b1;
    logic             init_done, stage_fail, pll_unlocked, mod_clk_en, conv_reg_reset;
    logic [1:0]       conv_err;

    int n_chk = 0;
    int n_fail = 0;
    int dly [NS];
    bit blk [NS];
    int cnt [NS];
    int log_q [16];
    int log_n = 0;
    logic [NS-1:0] prev_req = '0;

    always #2 clk = ~clk;

    fe_init_seq #(.SEL_W(SEL_W), .STAGE_TIMEOUT(TMO), .NCONV(2)) i_fe_init_seq (
        .clk              (clk),
        .rst_n            (rst_n),
        .force_init_i     (force_init),
        .io_enable_i      (io_enable),
        .clk_sel_i        (clk_sel),
        .stage_req_o      (stage_req),
        .stage_ack_i      (stage_ack),
        .window_narrow_i  (narrow),
        .pll_locked_i     (pll_locked),
        .init_done_o      (init_done),
        .stage_fail_o     (stage_fail),
        .conv_err_o       (conv_err),
        .pll_unlocked_o   (pll_unlocked),
        .mod_clk_en_o     (mod_clk_en),
        .conv_reg_reset_o (conv_reg_reset)
    );

    function automatic int exp_stage(input int pos);
        return pos;
    endfunction

    function automatic bit exp_reset_req(input int kind);
        return (kind == 1);
    endfunction

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    // stage stub and request-order monitor, driven 1 ns after each rising edge
    initial begin
        for (int i = 0; i < NS; i++) begin
            dly[i] = 1; blk[i] = 0; cnt[i] = 0;
        end
        forever begin
            @(posedge clk);
            #1;
            for (int i = 0; i < NS; i++) begin
                if (stage_req[i] && !blk[i]) begin
                    if (cnt[i] >= dly[i]) stage_ack[i] = 1'b1;
                    cnt[i]++;
                end else begin
                    cnt[i] = 0;
                    stage_ack[i] = 1'b0;
                end
            end
            if (stage_req != prev_req && stage_req != '0 && log_n < 16) begin
                for (int i = 0; i < NS; i++) if (stage_req[i]) log_q[log_n] = i;
                log_n++;
            end
            prev_req = stage_req;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    task automatic fire(input int kind);
        @(negedge clk);
        log_n = 0;
        case (kind)
            0: force_init = 1'b1;
            1: begin
                if (io_enable) begin
                    io_enable = 1'b0;
                    @(negedge clk);
                    log_n = 0;
                end
                io_enable = 1'b1;
            end
            default: clk_sel = clk_sel + SEL_W'(1 + ($urandom % 3));
        endcase
        @(negedge clk);
        force_init = 1'b0;
        chk(init_done == 1'b0, "R1 done low after trigger", int'(init_done), 0);
        chk(stage_req == 5'b00001, "R1 stage0 requested", int'(stage_req), 1);
        chk(conv_reg_reset == exp_reset_req(kind), "R4 reset pulse", int'(conv_reg_reset), int'(exp_reset_req(kind)));
        @(negedge clk);
        chk(conv_reg_reset == 1'b0, "R4 one cycle pulse", int'(conv_reg_reset), 0);
    endtask

    task automatic wait_done();
        bit prev_last = 0;
        int k = 0;
        bit rose_ok = 1;
        while (!init_done && !stage_fail && k < 300) begin
            prev_last = stage_req[NS-1] && stage_ack[NS-1];
            @(negedge clk);
            k++;
            if (init_done && !prev_last) rose_ok = 0;
        end
        chk(init_done == 1'b1, "R3 done reached", int'(init_done), 1);
        chk(rose_ok, "R3 done after last ack", int'(rose_ok), 1);
        chk(stage_fail == 1'b0, "R8 no fail", int'(stage_fail), 0);
        chk(log_n == NS, "R2 stage count", log_n, NS);
        for (int i = 0; i < NS && i < log_n; i++)
            chk(log_q[i] == exp_stage(i), "R2 stage order", log_q[i], exp_stage(i));
        chk(mod_clk_en == (init_done && !pll_unlocked), "R7 clock enable", int'(mod_clk_en), 1);
    endtask

    initial begin
        int seed_dummy;
        int k;
        seed_dummy = $urandom(32'd20251);

        // R10 reset state
        repeat (3) @(negedge clk);
        chk({init_done, stage_fail, pll_unlocked, mod_clk_en, conv_reg_reset} == '0, "R10 outputs in reset", 0, 0);
        chk(stage_req == '0 && conv_err == '0, "R10 req and flags in reset", int'(stage_req), 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        chk(init_done == 1'b0 && stage_req == '0, "R10 idle without trigger", int'(stage_req), 0);

        // directed first bring-up via I/O enable
        fire(1);
        wait_done();

        // R11 steady inputs do not retrigger
        repeat (20) @(negedge clk);
        chk(init_done == 1'b1, "R11 done held", int'(init_done), 1);
        chk(conv_reg_reset == 1'b0, "R11 no reset pulse", int'(conv_reg_reset), 0);

        // random runs
        for (int r = 0; r < 20; r++) begin
            int kind;
            kind = $urandom % 3;
            for (int i = 0; i < NS; i++) dly[i] = $urandom % 11;
            fire(kind);
            wait_done();
        end

        // R5 sticky converter errors
        @(negedge clk); narrow = 2'b10;
        @(negedge clk); narrow = 2'b00;
        chk(conv_err == 2'b10, "R5 flag set", int'(conv_err), 2);
        repeat (5) @(negedge clk);
        chk(conv_err == 2'b10, "R5 flag sticky", int'(conv_err), 2);
        narrow = 2'b01;
        @(negedge clk); narrow = 2'b00;
        chk(conv_err == 2'b11, "R5 second flag", int'(conv_err), 3);
        for (int i = 0; i < NS; i++) dly[i] = 2;
        dly[NS-1] = 6;
        fire(0);
        chk(conv_err == 2'b11, "R5 held until clear stage", int'(conv_err), 3);
        wait_done();
        chk(conv_err == 2'b00, "R5 cleared by run", int'(conv_err), 0);

        // R6 / R7 sticky unlock
        @(negedge clk); pll_locked = 1'b0;
        @(negedge clk); pll_locked = 1'b1;
        chk(pll_unlocked == 1'b1, "R6 unlock set", int'(pll_unlocked), 1);
        chk(mod_clk_en == 1'b0, "R7 clock gated", int'(mod_clk_en), 0);
        repeat (5) @(negedge clk);
        chk(pll_unlocked == 1'b1, "R6 unlock sticky", int'(pll_unlocked), 1);
        for (int i = 0; i < NS; i++) dly[i] = 8;
        fire(2);
        chk(pll_unlocked == 1'b0, "R6 cleared by trigger", int'(pll_unlocked), 0);
        pll_locked = 1'b0;
        @(negedge clk); pll_locked = 1'b1;
        @(negedge clk);
        chk(pll_unlocked == 1'b0, "R6 ignored during run", int'(pll_unlocked), 0);
        wait_done();
        chk(mod_clk_en == 1'b1, "R7 clock enabled", int'(mod_clk_en), 1);

        // R9 restart in mid-run
        for (int i = 0; i < NS; i++) dly[i] = 3;
        fire(0);
        k = 0;
        while (stage_req != 5'b00100 && k < 100) begin @(negedge clk); k++; end
        force_init = 1'b1;
        log_n = 0;
        @(negedge clk);
        force_init = 1'b0;
        chk(stage_req == 5'b00001, "R9 restart at stage0", int'(stage_req), 1);
        chk(init_done == 1'b0, "R9 done low", int'(init_done), 0);
        wait_done();

        // R8 stage timeout
        for (int i = 0; i < NS; i++) dly[i] = 2;
        blk[2] = 1;
        fire(0);
        k = 0;
        while (stage_req != 5'b00100 && k < 100) begin @(negedge clk); k++; end
        k = 0;
        while (!stage_fail && k < 100) begin @(negedge clk); k++; end
        chk(k == TMO, "R8 timeout cycle", k, TMO);
        chk(init_done == 1'b0 && stage_req == '0, "R8 quiet after fail", int'(stage_req), 0);
        repeat (10) @(negedge clk);
        chk(stage_fail == 1'b1 && init_done == 1'b0, "R8 fail held", int'(stage_fail), 1);
        blk[2] = 0;
        fire(0);
        chk(stage_fail == 1'b0, "R8 fail cleared by trigger", int'(stage_fail), 0);
        wait_done();

        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule